// File: doc/BRIEF.md
# Three-Source Complementary PWM Generator with Deadtime

This peripheral sits on the special function register bus of a small 8-bit controller core. It drives three PWM sources that share one period and one duty setting. Each source feeds a complementary pair of outputs. When the source changes level, the side that turns off drops at once, and the side that turns on waits a programmable number of timebase ticks. Sources two and three start a programmable phase delay after the source before them. Two sources can therefore drive an H-bridge, and three sources can drive a three-phase bridge.

All timing counts in ticks of an external timebase strobe (`tick_i`, nominally one pulse every 0.1 µs). Software writes the 16-bit settings as separate high and low bytes. Period, duty and phase writes first go to staging registers. They reach the running logic only at the end of the current source-1 period, or at once while the generator is disabled. A single enable bit starts and stops generation.

Top module: `tri_pwm_dt`

## Requirements
- R1: After reset, and one clock after `en_i` is low at a rising edge, all six bits of `pwm_o` are 0, and all counters restart from idle.
- R2: A write with `sfr_we_i` high updates one byte, chosen by `sfr_addr_i`: 0x9B/0x9C period high/low, 0x9D/0x9E duty high/low, 0x9F deadtime, 0xA2/0xA3 phase high/low. Other addresses change nothing.
- R3: Source 1 starts on the first tick after the enable is set. Its counter runs 0..P-1 with period P ticks (P=0 acts as 1). The source is high while the count is below the duty value D.
- R4: `pwm_o` bits 0, 2 and 4 carry the high sides of sources 1, 2 and 3. Bits 1, 3 and 5 carry their complements.
- R5: On each level change of a running source, the side turning off drops on that tick. The side turning on rises dt ticks later, where dt = 2 for deadtime value 0 and dt = value+1 otherwise (2..256 ticks).
- R6: D=0 holds the high side low and the low side high. D≥P holds the high side high and the low side low. Start-up from idle inserts no deadtime.
- R7: Source k+1 starts W·10 ticks after source k, where W is the phase register. A source never runs while the one before it is idle. Offsets beyond the period therefore wrap modulo the period.
- R8: A period, duty or phase write made while enabled takes effect only when source 1 completes its current period. A write made while disabled takes effect before the next enable.
- R9: Counters and outputs change only on clocks where `tick_i` is high. Between ticks, `pwm_o` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timebase strobe, one clock wide per tick |
| sfr_we_i | input | 1 | Register write strobe |
| sfr_addr_i | input | 8 | Register address |
| sfr_wdata_i | input | 8 | Register write data |
| en_i | input | 1 | Generator enable bit |
| pwm_o | output | 6 | Complementary output pairs |

## Verification
The main pattern is checked tick by tick against an independent waveform model in the bench. A short period with a short deadtime tests the count, the edge placement and the start-up without deadtime. A 600-tick period with the 256-tick maximum deadtime tests the top of the deadtime range. Duties of zero, equal to the period and above the period separate the constant-level paths from the normal compare path. Two phase settings, one shorter than the period and one longer, test the chained start of sources 2 and 3 and the modulo wrap. A period change made mid-period is told apart from an immediate update by the length of the running period. Sparse ticks show that nothing moves between strobes.

// File: rtl/tri_pwm_pkg.sv
package tri_pwm_pkg;
  localparam int unsigned REG_W       = 16;
  localparam int unsigned DT_W        = 8;
  localparam int unsigned SRC_N       = 3;
  localparam int unsigned TICKS_PER_US = 10;

  localparam logic [7:0] A_PER_HI  = 8'h9B;
  localparam logic [7:0] A_PER_LO  = 8'h9C;
  localparam logic [7:0] A_DUTY_HI = 8'h9D;
  localparam logic [7:0] A_DUTY_LO = 8'h9E;
  localparam logic [7:0] A_DEAD    = 8'h9F;
  localparam logic [7:0] A_PH_HI   = 8'hA2;
  localparam logic [7:0] A_PH_LO   = 8'hA3;

  // register value -> ticks, minimum 2
  function automatic logic [DT_W:0] dt_ticks(input logic [DT_W-1:0] v);
    logic [DT_W:0] r;
    r = {1'b0, v} + {{DT_W{1'b0}}, 1'b1};
    if (r < (DT_W+1)'(2)) r = (DT_W+1)'(2);
    return r;
  endfunction
endpackage

// File: rtl/tri_pwm_regs.sv
module tri_pwm_regs
  import tri_pwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [7:0]       addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             reload_i,
  output logic [REG_W-1:0] per_o,
  output logic [REG_W-1:0] duty_o,
  output logic [REG_W-1:0] ph_o,
  output logic [DT_W-1:0]  dt_o
);
  logic [REG_W-1:0] per_s, duty_s, ph_s;
  logic [REG_W-1:0] per_q, duty_q, ph_q;
  logic [DT_W-1:0]  dt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_s  <= '0;
      duty_s <= '0;
      ph_s   <= '0;
      dt_q   <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        A_PER_HI:  per_s[15:8]  <= wdata_i;
        A_PER_LO:  per_s[7:0]   <= wdata_i;
        A_DUTY_HI: duty_s[15:8] <= wdata_i;
        A_DUTY_LO: duty_s[7:0]  <= wdata_i;
        A_DEAD:    dt_q         <= wdata_i;
        A_PH_HI:   ph_s[15:8]   <= wdata_i;
        A_PH_LO:   ph_s[7:0]    <= wdata_i;
        default: ;
      endcase
    end
  end

  // active copies move only at a period boundary or while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= '0;
      duty_q <= '0;
      ph_q   <= '0;
    end else if (reload_i) begin
      per_q  <= per_s;
      duty_q <= duty_s;
      ph_q   <= ph_s;
    end
  end

  assign per_o  = per_q;
  assign duty_o = duty_q;
  assign ph_o   = ph_q;
  assign dt_o   = dt_q;

  // R8
  active_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reload_i |=> ($stable(per_q) && $stable(duty_q) && $stable(ph_q)));
endmodule

// File: rtl/tri_pwm_chan.sv
module tri_pwm_chan #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DLY_W = 20,
  parameter int unsigned DT_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             req_i,
  input  logic [DLY_W-1:0] off_i,
  input  logic [CNT_W-1:0] per_m1_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [DT_W:0]    dt_i,
  output logic             evt_o,
  output logic             run_o,
  output logic             wrap_o,
  output logic             hi_o,
  output logic             lo_o
);
  logic             started_q, raw_q;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [DLY_W-1:0] dly_q;
  logic [DT_W:0]    dtc_q;
  logic             waiting, raw_n, dt_ok;

  assign waiting = en_i & tick_i & req_i & ~started_q;
  assign evt_o   = waiting & (dly_q >= off_i);
  assign wrap_o  = en_i & tick_i & started_q & (cnt_q >= per_m1_i);

  always_comb begin
    if (evt_o || cnt_q >= per_m1_i) cnt_n = '0;
    else                            cnt_n = cnt_q + 1'b1;
  end
  assign raw_n = cnt_n < duty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      raw_q     <= 1'b0;
      cnt_q     <= '0;
      dly_q     <= '0;
      dtc_q     <= '1;
    end else if (!en_i) begin
      started_q <= 1'b0;
      raw_q     <= 1'b0;
      cnt_q     <= '0;
      dly_q     <= '0;
      dtc_q     <= '1;
    end else begin
      if (waiting && !evt_o) dly_q <= dly_q + 1'b1;
      if (tick_i && (started_q || evt_o)) begin
        started_q <= 1'b1;
        cnt_q     <= cnt_n;
        raw_q     <= raw_n;
        // start-up is not an edge: deadtime counter stays saturated
        if (started_q && (raw_n != raw_q)) dtc_q <= '0;
        else if (dtc_q < dt_i)             dtc_q <= dtc_q + 1'b1;
      end
    end
  end

  assign dt_ok = dtc_q >= dt_i;
  assign hi_o  = raw_q & dt_ok;
  assign lo_o  = started_q & ~raw_q & dt_ok;
  assign run_o = started_q;

  // R1
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!hi_o && !lo_o));

  // R9
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> ($stable(cnt_q) && $stable(started_q) && $stable(hi_o) && $stable(lo_o)));
endmodule

// File: rtl/tri_pwm_dt.sv
module tri_pwm_dt
  import tri_pwm_pkg::*;
#(
  parameter int unsigned NUM_SRC = SRC_N
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 sfr_we_i,
  input  logic [7:0]           sfr_addr_i,
  input  logic [7:0]           sfr_wdata_i,
  input  logic                 en_i,
  output logic [2*NUM_SRC-1:0] pwm_o
);
  localparam int unsigned DLY_W = REG_W + 4;

  logic [REG_W-1:0] per, duty, ph, per_m1;
  logic [DT_W-1:0]  dt_reg;
  logic [DT_W:0]    dt;
  logic [DLY_W-1:0] off_w;
  logic             reload;

  logic [NUM_SRC-1:0]            req, evt, run, wrap, hi, lo;
  logic [NUM_SRC-1:0][DLY_W-1:0] off;

  tri_pwm_regs i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (sfr_we_i),
    .addr_i   (sfr_addr_i),
    .wdata_i  (sfr_wdata_i),
    .reload_i (reload),
    .per_o    (per),
    .duty_o   (duty),
    .ph_o     (ph),
    .dt_o     (dt_reg)
  );

  assign reload = ~en_i | wrap[0];
  assign per_m1 = (per == '0) ? '0 : per - 1'b1;
  assign dt     = dt_ticks(dt_reg);
  // microseconds -> ticks: x8 + x2
  assign off_w  = (DLY_W'(ph) << 3) + (DLY_W'(ph) << 1);

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    if (k == 0) begin : g_first
      assign req[k] = en_i;
      assign off[k] = '0;
    end else begin : g_next
      assign req[k] = run[k-1] | evt[k-1];
      assign off[k] = off_w;

      // R7
      src_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run[k] |-> run[k-1]);
    end

    tri_pwm_chan #(
      .CNT_W (REG_W),
      .DLY_W (DLY_W),
      .DT_W  (DT_W)
    ) i_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en_i),
      .tick_i   (tick_i),
      .req_i    (req[k]),
      .off_i    (off[k]),
      .per_m1_i (per_m1),
      .duty_i   (duty),
      .dt_i     (dt),
      .evt_o    (evt[k]),
      .run_o    (run[k]),
      .wrap_o   (wrap[k]),
      .hi_o     (hi[k]),
      .lo_o     (lo[k])
    );

    assign pwm_o[2*k]   = hi[k];
    assign pwm_o[2*k+1] = lo[k];
  end
endmodule

// File: tb/test_tri_pwm_dt.sv
`timescale 1ns/1ps
module test_tri_pwm_dt;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       we = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       en = 1'b0;
  logic [5:0] pwm;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tri_pwm_dt i_tri_pwm_dt (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tick_i      (tick),
    .sfr_we_i    (we),
    .sfr_addr_i  (addr),
    .sfr_wdata_i (wdata),
    .en_i        (en),
    .pwm_o       (pwm)
  );

  task automatic chk(input string tag, input int n, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at step %0d: actual=%b expected=%b", tag, n, act, exp);
    end
  endtask

  // waveform model built from the requirements
  function automatic logic [5:0] exp_pwm(int n, int p, int d, int kr, int w);
    logic [5:0] r = '0;
    int dt = (kr == 0) ? 2 : kr + 1;
    int pe = (p == 0) ? 1 : p;
    for (int s = 0; s < 3; s++) begin
      int st = s * w * 10;
      if (n >= st) begin
        int m = n - st;
        int c = m % pe;
        bit raw = c < d;
        bit h, l;
        if (d == 0 || d >= pe) begin
          h = raw; l = !raw;
        end else if (raw) begin
          int since = (m < pe) ? 1000000 : c;
          h = since >= dt; l = 1'b0;
        end else begin
          h = 1'b0; l = (c - d) >= dt;
        end
        r[2*s]   = h;
        r[2*s+1] = l;
      end
    end
    return r;
  endfunction

  task automatic sfr_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  // R2: byte-wise configuration, loaded while disabled (R8)
  task automatic cfg(input int p, input int d, input int kr, input int w);
    logic [15:0] pv = p[15:0];
    logic [15:0] dv = d[15:0];
    logic [15:0] wv = w[15:0];
    @(negedge clk); en = 1'b0; tick = 1'b1;
    sfr_wr(8'h9B, pv[15:8]); sfr_wr(8'h9C, pv[7:0]);
    sfr_wr(8'h9D, dv[15:8]); sfr_wr(8'h9E, dv[7:0]);
    sfr_wr(8'h9F, kr[7:0]);
    sfr_wr(8'hA2, wv[15:8]); sfr_wr(8'hA3, wv[7:0]);
    sfr_wr(8'h9A, 8'h55);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_seq(input string tag, input int p, input int d, input int kr, input int w, input int len);
    cfg(p, d, kr, w);
    en = 1'b1;
    for (int n = 0; n < len; n++) begin
      @(posedge clk); @(negedge clk);
      chk(tag, n, pwm, exp_pwm(n, p, d, kr, w));
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 reset", 0, pwm, 6'b000000);
  endtask

  task automatic t_basic;
    run_seq("R2 R3 R4 R5 R6", 10, 4, 1, 0, 40);
  endtask

  task automatic t_disable;
    en = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1 disable", 0, pwm, 6'b000000);
    repeat (3) @(negedge clk);
    chk("R1 disable hold", 1, pwm, 6'b000000);
  endtask

  task automatic t_dead_max;
    run_seq("R5 max deadtime", 600, 300, 255, 0, 1300);
  endtask

  task automatic t_const;
    run_seq("R6 duty zero", 8, 0, 3, 0, 20);
    run_seq("R6 duty equal", 8, 8, 3, 0, 20);
    run_seq("R6 duty above", 8, 9, 3, 0, 20);
  endtask

  task automatic t_phase;
    run_seq("R7 phase", 20, 10, 2, 1, 80);
    run_seq("R7 phase wrap", 12, 5, 1, 2, 90);
  endtask

  // R8: period low byte rewritten mid-period; current period keeps 10 ticks
  task automatic t_shadow;
    cfg(10, 4, 1, 0);
    en = 1'b1;
    for (int n = 0; n < 24; n++) begin
      @(posedge clk); @(negedge clk);
      if (we) we = 1'b0;
      if (n == 8)  chk("R8 old period kept", n, {5'b0, pwm[0]}, 6'b000000);
      if (n == 9)  chk("R8 old period kept", n, pwm, exp_pwm(n, 10, 4, 1, 0));
      if (n == 14) chk("R8 new period", n, {5'b0, pwm[0]}, 6'b000000);
      if (n == 18) chk("R8 new period", n, {5'b0, pwm[0]}, 6'b000001);
      if (n == 2) begin
        we = 1'b1; addr = 8'h9C; wdata = 8'd6;
      end
    end
    en = 1'b0;
  endtask

  // R9: one tick every four clocks
  task automatic t_sparse;
    cfg(6, 3, 1, 0);
    tick = 1'b0;
    en = 1'b1;
    for (int n = 0; n < 20; n++) begin
      logic [5:0] e = exp_pwm(n, 6, 3, 1, 0);
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      chk("R9 tick step", n, pwm, e);
      repeat (3) @(negedge clk);
      chk("R9 hold between ticks", n, pwm, e);
    end
    tick = 1'b1;
    en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_disable();
    t_dead_max();
    t_const();
    t_phase();
    t_shadow();
    t_sparse();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule